// File: doc/BRIEF.md
# Programmable Pulse-Width Output Channel

This block drives one output pin either as a free-running pulse generator or as a plain static pin. The pulse generator alternates a high phase and a low phase. Each phase length is programmed through its own 16-bit register holding a value n, and the phase lasts n+1 ticks of a 1 µs enable strobe. One waveform period is therefore the high time plus the low time, and each phase can be set anywhere from 1 to 65536 ticks.

A 3-bit control register selects what the pin does. The mode bit selects the timer output, or hands the pin to the static controls: a drive bit and a level bit that either drive the pin low or high, or release it to high impedance. Writing the control register with the mode bit set starts the timer, or restarts it from the beginning of a high phase. Writing it with the mode bit clear stops the timer. The pad and the bus command decoding lie outside the block. The host should load both time registers before it enables the timer.

Top module: `pwm_channel`

## Requirements
- R1: After reset, both time registers and the control register are zero and the pin is released (`pin_oe`=0, `pin_out`=0).
- R2: Control bits are bit 2 = timer mode, bit 1 = drive, bit 0 = level. A write with mode=0 and drive=1 makes `pin_oe`=1 and `pin_out`=level on the cycle after the write.
- R3: A write with mode=0 and drive=0 releases the pin (`pin_oe`=0, `pin_out`=0) on the next cycle, whatever the level bit is.
- R4: A write with mode=1 enables the pin (`pin_oe`=1) whatever bits 1:0 hold. On the next cycle it starts a new high phase (`pin_out`=1), whether the timer was stopped or already running.
- R5: While the timer runs, the high phase lasts hi+1 ticks and the low phase lasts lo+1 ticks, and the two alternate. This holds at both ends of the range: value 0 gives 1 tick and value 65535 gives 65536 ticks.
- R6: The phase counter advances only on cycles where `tick` is 1. With no tick and no control write, `pin_out` holds its value.
- R7: A time value written while the timer runs leaves the current phase unchanged. It takes effect the next time a phase of that kind begins.
- R8: A write with mode=0 while the timer runs stops it. On the next cycle the pin follows the static bits and stays there regardless of ticks. A later activation begins with a full high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 1 µs time-base enable |
| hi_we | input | 1 | High-time register write strobe |
| hi_wdata | input | 16 | High-time value n (phase lasts n+1 ticks) |
| lo_we | input | 1 | Low-time register write strobe |
| lo_wdata | input | 16 | Low-time value n (phase lasts n+1 ticks) |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control value: bit 2 mode, bit 1 drive, bit 0 level |
| pin_out | output | 1 | Pin data value |
| pin_oe | output | 1 | Pin output enable (0 = high impedance) |

## Verification
The bench goes after the phase-length arithmetic at both ends of the range. A one-off counter would make a zero value give 0 or 2 ticks, or the 65535 value wrap after one tick. It writes time values partway through a phase: a design that loads them at once would shorten the running pulse. It also restarts the timer during a low phase, and a design that kept the old counter would return to high late. Finally, it stops the timer in mid-phase and feeds it sparse random ticks. This exposes a design that lets the pin toggle after the stop, or counts cycles instead of ticks.

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             hi_we,
  input  logic [CNT_W-1:0] hi_wdata,
  input  logic             lo_we,
  input  logic [CNT_W-1:0] lo_wdata,
  input  logic             ctl_we,
  input  logic [2:0]       ctl_wdata,
  output logic             pin_out,
  output logic             pin_oe
);

  localparam int MODE_B = 2;
  localparam int DRV_B  = 1;
  localparam int LVL_B  = 0;

  logic [CNT_W-1:0] hi_q, lo_q, cnt_q;
  logic [2:0]       ctl_q;
  logic             phase_hi_q;
  logic [CNT_W-1:0] hi_nxt, lo_nxt;

  assign hi_nxt = hi_we ? hi_wdata : hi_q;
  assign lo_nxt = lo_we ? lo_wdata : lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q       <= '0;
      lo_q       <= '0;
      ctl_q      <= '0;
      cnt_q      <= '0;
      phase_hi_q <= 1'b0;
    end else begin
      if (hi_we) hi_q <= hi_wdata;
      if (lo_we) lo_q <= lo_wdata;
      if (ctl_we) begin
        ctl_q <= ctl_wdata;
        if (ctl_wdata[MODE_B]) begin
          phase_hi_q <= 1'b1;
          cnt_q      <= hi_nxt;
        end else begin
          phase_hi_q <= 1'b0;
          cnt_q      <= '0;
        end
      end else if (ctl_q[MODE_B] && tick) begin
        if (cnt_q == '0) begin
          phase_hi_q <= ~phase_hi_q;
          cnt_q      <= phase_hi_q ? lo_nxt : hi_nxt;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign pin_oe  = ctl_q[MODE_B] | ctl_q[DRV_B];
  assign pin_out = ctl_q[MODE_B] ? phase_hi_q : (ctl_q[DRV_B] & ctl_q[LVL_B]);

  assert_static_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_wdata[MODE_B] && ctl_wdata[DRV_B]) |=> (pin_oe && pin_out == $past(ctl_wdata[LVL_B])));

  assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_wdata[MODE_B] && !ctl_wdata[DRV_B]) |=> (!pin_oe && !pin_out));

  assert_start_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[MODE_B]) |=> (pin_oe && pin_out));

  assert_boundary_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[MODE_B] && tick && !ctl_we && cnt_q == '0) |=> (pin_out != $past(pin_out)));

  assert_hold_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ctl_we) |=> $stable(pin_out));

  assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_wdata[MODE_B]) |=> (cnt_q == '0 && !phase_hi_q));

endmodule

// File: tb/pwm_channel_bench.sv
module pwm_channel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        hi_we = 1'b0, lo_we = 1'b0, ctl_we = 1'b0;
  logic [15:0] hi_wdata = '0, lo_wdata = '0;
  logic [2:0]  ctl_wdata = '0;
  logic        pin_out, pin_oe;

  int checks = 0;
  int fails = 0;
  int den = 1;
  bit done = 0;

  pwm_channel u_pwm_channel (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .hi_we(hi_we), .hi_wdata(hi_wdata),
    .lo_we(lo_we), .lo_wdata(lo_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always #10 clk = ~clk;

  function automatic int phase_ticks(input int n);
    return n + 1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_hi(input int v);
    @(negedge clk); tick = 0; hi_we = 1; hi_wdata = v[15:0];
    @(negedge clk); hi_we = 0;
  endtask

  task automatic wr_lo(input int v);
    @(negedge clk); tick = 0; lo_we = 1; lo_wdata = v[15:0];
    @(negedge clk); lo_we = 0;
  endtask

  task automatic wr_ctl(input logic [2:0] v);
    @(negedge clk); tick = 0; ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic measure(input logic lvl, input int limit, output int n);
    n = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (pin_out !== lvl) begin
        tick = 0;
        return;
      end
      tick = (($urandom % den) == 0);
      if (tick) n++;
    end
    n = -1;
  endtask

  initial begin
    int n;
    int bad;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 oe after reset", pin_oe, 0);
    check("R1 out after reset", pin_out, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 oe after release", pin_oe, 0);

    // R2 static drive
    wr_ctl(3'b011);
    check("R2 oe static high", pin_oe, 1);
    check("R2 out static high", pin_out, 1);
    wr_ctl(3'b010);
    check("R2 oe static low", pin_oe, 1);
    check("R2 out static low", pin_out, 0);
    // R3 release, level ignored
    wr_ctl(3'b001);
    check("R3 oe released", pin_oe, 0);
    check("R3 out released", pin_out, 0);

    // R5 reset-valued registers give 1-tick phases
    den = 1;
    wr_ctl(3'b100);
    check("R4 oe on start", pin_oe, 1);
    measure(1'b1, 100, n); check("R5 zero high len", n, phase_ticks(0));
    measure(1'b0, 100, n); check("R5 zero low len", n, phase_ticks(0));

    // R5 random lengths, R4 lower bits ignored
    for (int it = 0; it < 8; it++) begin
      int h, l;
      logic [1:0] lb;
      h = $urandom % 30; l = $urandom % 30; den = 1 + ($urandom % 4);
      lb = 2'($urandom);
      wr_hi(h); wr_lo(l);
      wr_ctl({1'b1, lb});
      check("R4 oe with mode", pin_oe, 1);
      check("R4 starts high", pin_out, 1);
      for (int p = 0; p < 2; p++) begin
        measure(1'b1, 1000, n); check("R5 random high len", n, phase_ticks(h));
        measure(1'b0, 1000, n); check("R5 random low len", n, phase_ticks(l));
      end
    end

    // R5 top of range
    den = 1;
    wr_hi(65535); wr_lo(0);
    wr_ctl(3'b100);
    measure(1'b1, 70000, n); check("R5 max high len", n, phase_ticks(65535));
    measure(1'b0, 100, n);   check("R5 after max low len", n, phase_ticks(0));

    // R7 mid-run updates
    den = 2;
    wr_hi(7); wr_lo(4);
    wr_ctl(3'b100);
    wr_hi(12); wr_lo(9);
    measure(1'b1, 1000, n); check("R7 current high unchanged", n, phase_ticks(7));
    measure(1'b0, 1000, n); check("R7 next low uses new", n, phase_ticks(9));
    measure(1'b1, 1000, n); check("R7 next high uses new", n, phase_ticks(12));

    // R4 restart during low phase
    den = 1;
    wr_hi(5); wr_lo(40);
    wr_ctl(3'b100);
    measure(1'b1, 1000, n); check("R4 pre-restart high", n, phase_ticks(5));
    for (int i = 0; i < 10; i++) begin @(negedge clk); tick = 1; end
    @(negedge clk); tick = 0;
    check("R4 in low before restart", pin_out, 0);
    wr_ctl(3'b111);
    check("R4 restart goes high", pin_out, 1);
    measure(1'b1, 1000, n); check("R4 restart full high", n, phase_ticks(5));

    // R6 hold without ticks
    wr_hi(2);
    wr_ctl(3'b100);
    bad = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); tick = 0;
      if (pin_out !== 1'b1) bad++;
    end
    check("R6 holds without tick", bad, 0);

    // R8 stop in mid-phase
    wr_hi(30); wr_lo(30);
    wr_ctl(3'b100);
    for (int i = 0; i < 5; i++) begin @(negedge clk); tick = 1; end
    wr_ctl(3'b010);
    check("R8 stop oe", pin_oe, 1);
    check("R8 stop out", pin_out, 0);
    bad = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); tick = 1;
      if (pin_out !== 1'b0) bad++;
    end
    tick = 0;
    check("R8 stays static under ticks", bad, 0);
    wr_ctl(3'b000);
    check("R8 stop to release", pin_oe, 0);
    den = 3;
    wr_ctl(3'b100);
    measure(1'b1, 1000, n); check("R8 reactivation full high", n, phase_ticks(30));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule